// File: doc/BRIEF.md
# Per-Bit Pattern-Match Interrupt Unit for a Parallel Port

This unit gives an eight-pin parallel port a bit-level operating mode. Each pin can be set as an input or an output, and the port raises an interrupt when a chosen set of pins reaches a chosen logic level. The host writes all setup as a stream of byte-wide control words on a single write port. A mode-select word picks the port mode. In the bit-level mode it is followed by a direction word. An interrupt word sets the enable and picks either "any pin" or "every pin" matching, and either a high or a low active level. It can also say that the next word is an exclusion mask.

A separate data write loads the output register, which drives the pins set as outputs. Pin inputs pass through one sampling register. Each monitored bit is taken from the sampled pin if that bit is an input, and from the output register if it is an output. The request output gives a one-cycle pulse each time the programmed condition goes from false to true. It also pulses when the enable is set while the condition already holds.

Top module: `pio_bitctl_irq`

## Requirements
- R1: After reset, `irq` is 0, `pin_out` is 0x00 and `pin_oe` is 0x00. The port starts in input mode, every bit is excluded by the mask, and the interrupt is disabled.
- R2: A control word whose low nibble is 1111 selects the port mode from bits [7:6]: 00 output, 01 input, 10 bidirectional, 11 bit-level. `pin_oe` is 0xFF in output mode and 0x00 in input and bidirectional modes.
- R3: The control word that follows a bit-level mode select is always stored as the direction register (1 = input, 0 = output), even if its low nibble is 1111. In bit-level mode, `pin_oe` is the inverse of that register.
- R4: A control word whose low nibble is 0111 is the interrupt word. Bit 7 is the enable, bit 6 selects every-bit (1) or any-bit (0) matching, bit 5 selects active high (1) or active low (0), and bit 4 = 1 makes the next control word the mask.
- R5: A mask bit of 1 removes that bit from monitoring, so that bit has no effect on `irq`. When every bit is masked, `irq` never asserts.
- R6: In any-bit matching, the condition holds when at least one monitored bit is at the active level.
- R7: In every-bit matching, the condition holds only when all monitored bits are at the active level.
- R8: With active low selected, a monitored bit matches when it is 0.
- R9: A bit set as an output is monitored through the output register. Its pin input is ignored, so writing a matching output value raises the request.
- R10: `irq` is a single-cycle pulse each time the condition becomes true. It does not repeat while the condition holds, and it fires again only after the condition has gone false and then true. It asserts two clock edges after a pin change (one sampling edge, then the request edge) and one edge after a control or data write.
- R11: If the condition already holds when a write sets the enable, `irq` pulses one edge after that write.
- R12: Outside bit-level mode, an interrupt word's bits 6..4 are ignored: they are not stored and no mask word is expected. `irq` never asserts in those modes.
- R13: While the enable is 0, `irq` stays 0 whatever the monitored bits do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word |
| data_we | input | 1 | Output register write strobe |
| data_wdata | input | 8 | Output register value |
| pin_in | input | 8 | Levels seen on the port pins |
| pin_out | output | 8 | Output register value driven to the pins |
| pin_oe | output | 8 | Per-pin drive enable (1 = driven) |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
If the word sequencer loses its place, the next write lands in the wrong register. This shows up at once as a wrong `pin_oe` pattern, or one write later as a pulse that is missing or comes too early. A wrong mask, level or matching selector shows as a missing or extra pulse two edges after the pin change that should, or should not, complete the match. A stale "already reported" flag either turns one pulse into repeats or swallows the next genuine transition. The tests therefore count pulses over fixed windows and check in which cycle the first one appears.

// File: rtl/pio_bitctl_pkg.sv
package pio_bitctl_pkg;

  typedef enum logic [1:0] {
    PM_OUT   = 2'b00,
    PM_IN    = 2'b01,
    PM_BIDIR = 2'b10,
    PM_BIT   = 2'b11
  } port_mode_e;

  typedef enum logic [1:0] {
    SQ_CMD  = 2'd0,
    SQ_DIR  = 2'd1,
    SQ_MASK = 2'd2
  } seq_e;

  typedef struct packed {
    logic en;
    logic all_of;
    logic hi_act;
  } irq_cfg_t;

  // control word decode: low-nibble tags and field positions
  localparam logic [3:0] TAG_MODE = 4'b1111;
  localparam logic [3:0] TAG_ICW  = 4'b0111;
  localparam int F_MODE_HI = 7;
  localparam int F_MODE_LO = 6;
  localparam int F_EN      = 7;
  localparam int F_ALL     = 6;
  localparam int F_HI      = 5;
  localparam int F_MFOLLOW = 4;

endpackage

// File: rtl/pio_bitctl_seq.sv
module pio_bitctl_seq
  import pio_bitctl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output port_mode_e   mode,
  output logic [W-1:0] dir,
  output logic [W-1:0] mask,
  output irq_cfg_t     cfg,
  output seq_e         seq
);

  logic is_mode_word;
  logic is_icw;

  assign is_mode_word = (wdata[3:0] == TAG_MODE);
  assign is_icw       = (wdata[3:0] == TAG_ICW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= PM_IN;
      dir  <= '1;
      mask <= '1;
      cfg  <= '0;
      seq  <= SQ_CMD;
    end else if (we) begin
      case (seq)
        SQ_DIR: begin
          dir <= wdata;
          seq <= SQ_CMD;
        end
        SQ_MASK: begin
          mask <= wdata;
          seq  <= SQ_CMD;
        end
        default: begin
          if (is_mode_word) begin
            mode <= port_mode_e'(wdata[F_MODE_HI:F_MODE_LO]);
            if (wdata[F_MODE_HI:F_MODE_LO] == 2'b11) seq <= SQ_DIR;
          end else if (is_icw) begin
            cfg.en <= wdata[F_EN];
            if (mode == PM_BIT) begin
              cfg.all_of <= wdata[F_ALL];
              cfg.hi_act <= wdata[F_HI];
              if (wdata[F_MFOLLOW]) seq <= SQ_MASK;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pio_bitctl_match.sv
module pio_bitctl_match
  import pio_bitctl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] pin_q,
  input  logic [W-1:0] out_reg,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] mask,
  input  irq_cfg_t     cfg,
  output logic [W-1:0] hit,
  output logic         match
);

  localparam logic [W-1:0] ALL_ONES = '1;

  // any-bit / every-bit reduction over the monitored set
  function automatic logic reduce_hits(input logic [W-1:0] h,
                                       input logic [W-1:0] m,
                                       input logic all_of);
    logic watched;
    watched = (m != ALL_ONES);
    if (!watched) return 1'b0;
    if (all_of) return ((h | m) == ALL_ONES);
    return (h != '0);
  endfunction

  logic [W-1:0] seen;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign seen[i] = dir[i] ? pin_q[i] : out_reg[i];
    assign hit[i]  = ~mask[i] & ~(seen[i] ^ cfg.hi_act);
  end

  assign match = reduce_hits(hit, mask, cfg.all_of);

endmodule

// File: rtl/pio_bitctl_pulse.sv
module pio_bitctl_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic match,
  output logic cond,
  output logic irq
);

  logic reported;

  assign cond = arm & match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reported <= 1'b0;
      irq      <= 1'b0;
    end else begin
      reported <= cond;
      irq      <= cond & ~reported;
    end
  end

endmodule

// File: rtl/pio_bitctl_irq.sv
module pio_bitctl_irq
  import pio_bitctl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [W-1:0] ctrl_wdata,
  input  logic         data_we,
  input  logic [W-1:0] data_wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         irq
);

  port_mode_e   mode;
  logic [W-1:0] dir;
  logic [W-1:0] mask;
  irq_cfg_t     cfg;
  seq_e         seq;
  logic [W-1:0] out_reg;
  logic [W-1:0] pin_q;
  logic [W-1:0] hit;
  logic         match;
  logic         cond;
  logic         bit_mode;
  logic         int_en;

  pio_bitctl_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
    .mode(mode), .dir(dir), .mask(mask), .cfg(cfg), .seq(seq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_reg <= '0;
      pin_q   <= '0;
    end else begin
      pin_q <= pin_in;
      if (data_we) out_reg <= data_wdata;
    end
  end

  pio_bitctl_match #(.W(W)) u_match (
    .pin_q(pin_q), .out_reg(out_reg), .dir(dir), .mask(mask),
    .cfg(cfg), .hit(hit), .match(match)
  );

  assign bit_mode = (mode == PM_BIT);
  assign int_en   = cfg.en;

  pio_bitctl_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .arm(bit_mode & int_en),
    .match(match), .cond(cond), .irq(irq)
  );

  always_comb begin
    case (mode)
      PM_OUT:  pin_oe = '1;
      PM_BIT:  pin_oe = ~dir;
      default: pin_oe = '0;
    endcase
  end

  assign pin_out = out_reg;

endmodule

// File: rtl/pio_bitctl_chk.sv
module pio_bitctl_chk
  import pio_bitctl_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ctrl_we,
  input logic [W-1:0] ctrl_wdata,
  input logic         irq,
  input logic         cond,
  input logic         bit_mode,
  input logic         int_en,
  input logic [W-1:0] mask,
  input seq_e         seq
);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r10_rise_fires: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cond) |=> irq);

  a_r13_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> !irq);

  a_r12_other_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_mode |=> !irq);

  a_r5_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |=> !irq);

  a_r3_dir_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && seq == SQ_CMD && ctrl_wdata[3:0] == TAG_MODE &&
     ctrl_wdata[7:6] == 2'b11) |=> (seq == SQ_DIR));

  a_r4_mask_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && seq == SQ_CMD && ctrl_wdata[3:0] == TAG_ICW &&
     ctrl_wdata[4] && bit_mode) |=> (seq == SQ_MASK));

endmodule

bind pio_bitctl_irq pio_bitctl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .irq(irq), .cond(cond), .bit_mode(bit_mode), .int_en(int_en),
  .mask(mask), .seq(seq)
);

// File: tb/pio_bitctl_irq_test.sv
`timescale 1ns/1ps
module pio_bitctl_irq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic       data_we = 1'b0;
  logic [7:0] data_wdata = '0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pio_bitctl_irq uut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: act=%0d exp<=20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk); pin_in = v;
  endtask

  // count irq highs over n edges and record the first edge index (1-based)
  task automatic watch(input int n, output int cnt, output int first);
    cnt = 0; first = 0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1;
      if (irq) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
  endtask

  task automatic t_reset;
    int c, f;
    #1;
    check("R1 irq", irq, 0);
    check("R1 pin_out", pin_out, 8'h00);
    check("R1 pin_oe", pin_oe, 8'h00);
    set_pins(8'hFF);
    watch(4, c, f);
    check("R1 R5 no irq all masked", c, 0);
    set_pins(8'h00);
  endtask

  task automatic t_modes;
    wr_ctrl(8'h0F); #1 check("R2 output mode oe", pin_oe, 8'hFF);
    wr_ctrl(8'h8F); #1 check("R2 bidir mode oe", pin_oe, 8'h00);
    wr_ctrl(8'h4F); #1 check("R2 input mode oe", pin_oe, 8'h00);
  endtask

  task automatic t_dir;
    wr_ctrl(8'hCF);
    wr_ctrl(8'h0F); #1 check("R3 dir word taken as data", pin_oe, 8'hF0);
    wr_ctrl(8'h03); #1 check("R3 dir holds", pin_oe, 8'hF0);
  endtask

  task automatic t_or_high;
    int c, f;
    wr_ctrl(8'hB7); wr_ctrl(8'hF0);
    watch(4, c, f); check("R6 quiet when no bit high", c, 0);
    set_pins(8'h04); watch(6, c, f);
    check("R6 any-bit count", c, 1); check("R10 latency pin", f, 2);
    set_pins(8'h06); watch(6, c, f); check("R10 no repeat while held", c, 0);
    set_pins(8'h00); watch(3, c, f);
    set_pins(8'h01); watch(6, c, f); check("R10 refire", c, 1);
    set_pins(8'h00); watch(3, c, f);
    wr_ctrl(8'hB7); wr_ctrl(8'h0E);
    set_pins(8'h0E); watch(6, c, f); check("R5 masked bits ignored", c, 0);
    set_pins(8'h0F); watch(6, c, f); check("R5 unmasked bit fires", c, 1);
  endtask

  task automatic t_and_high;
    int c, f;
    set_pins(8'h00);
    wr_ctrl(8'hF7); wr_ctrl(8'hF0);
    set_pins(8'h07); watch(6, c, f); check("R7 partial no irq", c, 0);
    set_pins(8'h0F); watch(6, c, f);
    check("R7 all bits fire", c, 1); check("R7 latency", f, 2);
  endtask

  task automatic t_and_low;
    int c, f;
    wr_ctrl(8'hD7); wr_ctrl(8'hF0);
    set_pins(8'h08); watch(6, c, f); check("R8 one high blocks", c, 0);
    set_pins(8'h00); watch(6, c, f); check("R8 all low fire", c, 1);
  endtask

  task automatic t_outputs;
    int c, f;
    set_pins(8'h00);
    wr_ctrl(8'hB7); wr_ctrl(8'h0F);
    set_pins(8'hF0); watch(6, c, f); check("R9 pins on outputs ignored", c, 0);
    wr_data(8'h20); watch(4, c, f);
    check("R9 output bit fires", c, 1); check("R10 latency data", f, 1);
  endtask

  task automatic t_enable;
    int c, f;
    wr_ctrl(8'h37); wr_ctrl(8'h0F);
    wr_data(8'h00); wr_data(8'h40); watch(6, c, f);
    check("R13 disabled quiet", c, 0);
    wr_ctrl(8'hA7); watch(4, c, f);
    check("R11 pending fires", c, 1); check("R11 latency", f, 1);
  endtask

  task automatic t_other_mode;
    int c, f;
    wr_data(8'h00);
    wr_ctrl(8'h4F); #1 check("R12 input mode oe", pin_oe, 8'h00);
    wr_data(8'h80); set_pins(8'hFF); watch(6, c, f);
    check("R12 no irq outside bit mode", c, 0);
    wr_data(8'h00); set_pins(8'h00);
    wr_ctrl(8'h97);
    wr_ctrl(8'hCF);
    wr_ctrl(8'h0F); #1 check("R12 no mask expected", pin_oe, 8'hF0);
    watch(6, c, f); check("R12 level bit not stored", c, 0);
    wr_data(8'h80); watch(4, c, f); check("R12 high level kept", c, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_modes();
    t_dir();
    t_or_high();
    t_and_high();
    t_and_low();
    t_outputs();
    t_enable();
    t_other_mode();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule